// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block takes a 4-bit binary-coded decimal value (8421 weighting, bit 3 most significant) and turns it into the seven active-high segment drives of a numeric display digit. A capture latch sits in front of the decoder. While the latch control is low, the digit follows the live input. When the control rises, the value present at that moment is frozen until the control drops again. This lets a counter or bus keep changing while the display stays still.

Two overrides act after the decoder. They take effect in the same cycle. A lamp-test input (active low) lights every segment so a test can find dead segments. A blanking input (active low) darkens the digit. A brightness controller outside the block can toggle the blanking input quickly to dim the display. Lamp test wins over blanking, and blanking wins over the decoded data. Codes above nine have no decimal digit and show as a dark display.

The block is fully synchronous to one system clock. The latch control is sampled on that clock. A parameter can add a registered output stage, which costs one cycle of latency.

Top module: `bcd7_latch_decoder`

## Requirements
- R1: `seg` is active high with bit 0 = segment a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f, bit 6 = g; a 1 lights the segment.
- R2: While `le` is low, the decoded digit follows `bcd` in the same cycle.
- R3: At the first clock edge where `le` is sampled high after being low, `bcd` is captured. While `le` stays high the output shows the captured value, and later changes on `bcd` have no effect.
- R4: While `lt_n` is low, `seg` is 7'h7F, whatever `bi_n`, `le` and `bcd` are.
- R5: While `bi_n` is low and `lt_n` is high, `seg` is 7'h00, whatever the data.
- R6: Codes 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7C, 07, 7F, 67 (hex). Digit 6 has no segment a and digit 9 has no segment d.
- R7: Codes 10 to 15 give 7'h00.
- R8: After reset the latch holds 0 and counts as closed. With `le` held high and both overrides inactive, `seg` shows 7'h3F whatever `bcd` is.
- R9: With `REG_OUT` = 1, `seg` shows the same value as the unregistered build, one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| le | input | 1 | Latch control: low = transparent, high = hold |
| bi_n | input | 1 | Blanking, active low |
| lt_n | input | 1 | Lamp test, active low |
| bcd | input | 4 | BCD data, bit 3 most significant |
| seg | output | 7 | Segment drives, bit 0 = a through bit 6 = g |

## Verification
A latch capture can land in the same cycle as an active override. The captured value must still be correct once the override is released. The bench provokes this by raising `le` on a code while lamp test or blanking is active, then changing `bcd`. It then drops `le` and checks that the live code is tracked again. Every one of the 16 codes is run under all four override combinations, both open and held. The scoreboard's expected pattern follows the fixed priority order and a separate digit table. A second instance with the output register enabled is compared against the same expectations one cycle later.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_N = 7;
  localparam int MAX_DIGIT = 9;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_N-1:0] seg_t;

  localparam seg_t SEG_ALL_ON  = {SEG_N{1'b1}};
  localparam seg_t SEG_ALL_OFF = {SEG_N{1'b0}};

  // Segment pattern per decimal digit, bit 0 = a ... bit 6 = g.
  function automatic seg_t digit_pattern(input bcd_t code);
    seg_t p;
    unique case (code)
      4'd0:    p = 7'b011_1111;
      4'd1:    p = 7'b000_0110;
      4'd2:    p = 7'b101_1011;
      4'd3:    p = 7'b100_1111;
      4'd4:    p = 7'b110_0110;
      4'd5:    p = 7'b110_1101;
      4'd6:    p = 7'b111_1100;
      4'd7:    p = 7'b000_0111;
      4'd8:    p = 7'b111_1111;
      4'd9:    p = 7'b110_0111;
      default: p = SEG_ALL_OFF;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/bcd7_input_latch.sv
module bcd7_input_latch
  import bcd7_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic le,
  input  bcd_t bcd_in,
  output bcd_t code_out
);
  bcd_t held_q, held_d;
  logic le_q, le_d;
  logic cap_en;
  logic closed;

  // Capture on the first sampled-high edge of le.
  assign cap_en = le & ~le_q;
  assign closed = le & le_q;

  always_comb begin
    held_d = held_q;
    if (cap_en) held_d = bcd_in;
    le_d = le;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      le_q   <= 1'b1;
    end else begin
      le_q <= le_d;
      if (cap_en) held_q <= held_d;
    end
  end

  assign code_out = closed ? held_q : bcd_in;

  AST_OPEN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    !le |-> (code_out == bcd_in)); // R2
  AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(le) |=> (held_q == $past(bcd_in))); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (le && $past(le)) |=> $stable(held_q)); // R3
endmodule

// File: rtl/bcd7_seg_decode.sv
module bcd7_seg_decode
  import bcd7_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  bcd_t code,
  output seg_t pattern
);
  always_comb pattern = digit_pattern(code);

  AST_NONDEC_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (code > bcd_t'(MAX_DIGIT)) |-> (pattern == SEG_ALL_OFF)); // R7
  AST_DIGIT_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (code <= bcd_t'(MAX_DIGIT)) |-> ($countones(pattern) >= 2)); // R6
endmodule

// File: rtl/bcd7_seg_override.sv
module bcd7_seg_override
  import bcd7_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lt_n,
  input  logic bi_n,
  input  seg_t pattern,
  output seg_t seg_out
);
  always_comb begin
    if (!lt_n)      seg_out = SEG_ALL_ON;
    else if (!bi_n) seg_out = SEG_ALL_OFF;
    else            seg_out = pattern;
  end

  AST_LAMP_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !lt_n |-> (seg_out == SEG_ALL_ON)); // R4
  AST_BLANK_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_n && !bi_n) |-> (seg_out == SEG_ALL_OFF)); // R5
  AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_n && bi_n) |-> (seg_out == pattern)); // R1
endmodule

// File: rtl/bcd7_latch_decoder.sv
module bcd7_latch_decoder
  import bcd7_pkg::*;
#(
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le,
  input  logic             bi_n,
  input  logic             lt_n,
  input  logic [BCD_W-1:0] bcd,
  output logic [SEG_N-1:0] seg
);
  bcd_t code_sel;
  seg_t dec_pat;
  seg_t seg_comb;

  bcd7_input_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .le       (le),
    .bcd_in   (bcd),
    .code_out (code_sel)
  );

  bcd7_seg_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (code_sel),
    .pattern (dec_pat)
  );

  bcd7_seg_override u_ovr (
    .clk     (clk),
    .rst_n   (rst_n),
    .lt_n    (lt_n),
    .bi_n    (bi_n),
    .pattern (dec_pat),
    .seg_out (seg_comb)
  );

  generate
    if (REG_OUT) begin : g_reg
      seg_t seg_q, seg_d;
      always_comb seg_d = seg_comb;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seg_q <= SEG_ALL_OFF;
        else        seg_q <= seg_d;
      end
      assign seg = seg_q;
      AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (seg == $past(seg_comb))); // R9
    end else begin : g_comb
      assign seg = seg_comb;
    end
  endgenerate
endmodule

// File: tb/bcd7_latch_decoder_test.sv
module bcd7_latch_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic le = 1'b1, bi_n = 1'b1, lt_n = 1'b1;
  logic [3:0] bcd = 4'd5;
  logic [6:0] seg, seg_r;

  typedef struct { logic [6:0] exp; string req; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  bcd7_latch_decoder #(.REG_OUT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .le(le), .bi_n(bi_n), .lt_n(lt_n), .bcd(bcd), .seg(seg));
  bcd7_latch_decoder #(.REG_OUT(1'b1)) uut_reg (
    .clk(clk), .rst_n(rst_n), .le(le), .bi_n(bi_n), .lt_n(lt_n), .bcd(bcd), .seg(seg_r));

  // Digit table from R6/R7 (bit 0 = a .. bit 6 = g, R1).
  function automatic logic [6:0] ref_digit(input logic [3:0] c);
    case (c)
      4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
      4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
      4'd6: return 7'h7C;  4'd7: return 7'h07;  4'd8: return 7'h7F;
      4'd9: return 7'h67;  default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] ref_out(input logic l, input logic b, input logic [3:0] c);
    if (!l) return 7'h7F;
    if (!b) return 7'h00;
    return ref_digit(c);
  endfunction

  function automatic string tag(input logic l, input logic b, input logic [3:0] c, input string base);
    if (!l) return {base, "/R4"};
    if (!b) return {base, "/R5"};
    if (c > 4'd9) return {base, "/R7"};
    return {base, "/R6/R1"};
  endfunction

  task automatic apply(input logic l, input logic b, input logic e, input logic [3:0] c,
                       input logic [6:0] exp, input string req);
    @(negedge clk);
    lt_n = l; bi_n = b; le = e; bcd = c;
    sb.push_back('{exp, req});
  endtask

  // Monitor: sample mid-low-phase, well away from the rising edge.
  initial begin
    logic [6:0] prev_exp;
    bit prev_ok;
    prev_ok = 1'b0;
    prev_exp = '0;
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (seg !== it.exp) begin
          fails++;
          $display("FAIL %s: seg=%h expected %h", it.req, seg, it.exp);
        end
        if (prev_ok) begin
          checks++;
          if (seg_r !== prev_exp) begin
            fails++;
            $display("FAIL R9: registered seg=%h expected %h", seg_r, prev_exp);
          end
        end
        prev_exp = it.exp;
        prev_ok = 1'b1;
      end else prev_ok = 1'b0;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: latch closed holding 0 out of reset, data ignored.
    apply(1, 1, 1, 4'd5, 7'h3F, "R8");
    apply(1, 1, 1, 4'd9, 7'h3F, "R8");
    for (int ov = 3; ov >= 0; ov--) begin
      logic l, b;
      l = ov[1]; b = ov[0];
      for (int k = 0; k < 16; k++) begin
        logic [3:0] c;
        c = 4'(k);
        apply(l, b, 0, c, ref_out(l, b, c), tag(l, b, c, "R2"));
      end
      for (int k = 0; k < 16; k++) begin
        logic [3:0] c, o;
        c = 4'(k);
        o = c + 4'd3;
        apply(l, b, 0, c, ref_out(l, b, c), tag(l, b, c, "R2"));
        apply(l, b, 1, c, ref_out(l, b, c), tag(l, b, c, "R3"));
        apply(l, b, 1, ~c, ref_out(l, b, c), tag(l, b, c, "R3"));
        apply(l, b, 1, o, ref_out(l, b, c), tag(l, b, c, "R3"));
        // Override released while held: captured value must reappear.
        apply(1, 1, 1, o, ref_digit(c), "R3");
        apply(l, b, 0, o, ref_out(l, b, o), tag(l, b, o, "R2"));
      end
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule